// File: doc/BRIEF.md
# Store-to-Load Memory Hazard Gate

This block decides, in the same cycle it is asked, whether a pending load may start its memory-access step. It scans the store entries of the reorder buffer directly instead of a separate load/store queue. A load is held back while any older, active store entry either targets the load's exact address or has not yet resolved its address. No data is forwarded. Because stores write memory only at commit, a held load proceeds once every blocking store has retired and its entry has been freed.

The reorder buffer supplies its head pointer and, for each entry, an active bit, a store-type bit, an address-valid bit and the destination address. The load supplies its effective address and its own buffer index. Age is the circular distance from the head pointer, so the oldest entry has age 0. When the load stalls, the block also reports the index of the youngest older store that is holding it back, so the scheduler knows which commit to wait for.

Top module: `ldst_hazard_gate`

## Requirements
- R1: While `ld_valid_i` is 0, `ld_go_o`, `ld_stall_o` and `blk_idx_o` are all 0, whatever the entry state.
- R2: With `ld_valid_i` at 1 and no older active store that has a matching or unresolved address, `ld_go_o` is 1 and `ld_stall_o` is 0 in the same cycle.
- R3: An older entry with active=1, store=1, address-valid=1 and an address equal to `ld_addr_i` makes `ld_stall_o` 1.
- R4: An older entry with active=1, store=1 and address-valid=0 makes `ld_stall_o` 1, whatever its address field holds.
- R5: An entry with active=0 never causes a stall.
- R6: An entry with store=0 never causes a stall.
- R7: The age of entry e is (e - head) mod N_ENT. Only entries whose age is below the load's own age are compared, so younger stores and the load's own entry are ignored.
- R8: The address compare covers all ADDR_W bits. A difference in any single bit means no match.
- R9: While stalled, `blk_idx_o` holds the index of the blocking store with the largest age below the load's age. It is 0 whenever `ld_stall_o` is 0.
- R10: With `ld_valid_i` at 1, exactly one of `ld_go_o` and `ld_stall_o` is 1.
- R11: A load at the head entry (index equal to `head_idx_i`) is always granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ld_valid_i | input | 1 | A load is waiting to start its memory access |
| ld_addr_i | input | ADDR_W | Effective address of the load |
| ld_idx_i | input | IDX_W | Reorder-buffer index of the load |
| head_idx_i | input | IDX_W | Index of the oldest reorder-buffer entry |
| ent_busy_i | input | N_ENT | Per-entry active (allocated, not committed) bit |
| ent_is_st_i | input | N_ENT | Per-entry store-type bit |
| ent_addr_ok_i | input | N_ENT | Per-entry destination-address-valid bit |
| ent_addr_i | input | N_ENT x ADDR_W | Per-entry destination address |
| ld_go_o | output | 1 | Load may start its memory access |
| ld_stall_o | output | 1 | Load must wait |
| blk_idx_o | output | IDX_W | Youngest older blocking store, 0 when not stalled |

## Verification
The block holds no state, so any fault shows on the ports in the same cycle as the input pattern that exposes it. A wrong age rotation or head wrap shows up as younger stores stalling a load, or older ones being missed, for particular head and load positions. A faulty priority pick reports an older blocker instead of the youngest one. A comparator fault shows up as a grant despite a match, or a stall caused by a one-bit address difference. The bench therefore sweeps every head and load position against every mix of entry classes on a four-entry buffer.

// File: rtl/ldst_hz_pkg.sv
package ldst_hz_pkg;
  // distance from base to pos going forward around a ring of n slots
  function automatic int unsigned ring_dist(int unsigned pos, int unsigned base, int unsigned n);
    return (pos >= base) ? pos - base : pos + n - base;
  endfunction

  function automatic int unsigned ring_add(int unsigned base, int unsigned off, int unsigned n);
    return (base + off >= n) ? base + off - n : base + off;
  endfunction
endpackage

// File: rtl/hz_ent_cmp.sv
module hz_ent_cmp #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]            ld_addr_i,
  input  logic [N_ENT-1:0]             ent_busy_i,
  input  logic [N_ENT-1:0]             ent_is_st_i,
  input  logic [N_ENT-1:0]             ent_addr_ok_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0] ent_addr_i,
  output logic [N_ENT-1:0]             cand_o
);
  // unresolved store address cannot be ruled out, so it counts as a hit
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign cand_o[g] = ent_busy_i[g] & ent_is_st_i[g]
                     & (~ent_addr_ok_i[g] | (ent_addr_i[g] == ld_addr_i));
  end
endmodule

// File: rtl/hz_age_rot.sv
module hz_age_rot
  import ldst_hz_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [IDX_W-1:0] head_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [N_ENT-1:0] cand_i,
  output logic [N_ENT-1:0] ord_o
);
  logic [IDX_W-1:0] ld_age;

  assign ld_age = IDX_W'(ring_dist(int'(ld_idx_i), int'(head_i), N_ENT));

  // slot a of ord_o holds the entry of age a, kept only if older than the load
  for (genvar a = 0; a < N_ENT; a++) begin : g_slot
    logic [IDX_W-1:0] src;
    assign src      = IDX_W'(ring_add(int'(head_i), a, N_ENT));
    assign ord_o[a] = cand_i[src] & (IDX_W'(a) < ld_age);
  end
endmodule

// File: rtl/hz_pick_hi.sv
module hz_pick_hi #(
  parameter int N_ENT = 16,
  parameter int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] pos_o
);
  always_comb begin
    hit_o = 1'b0;
    pos_o = '0;
    for (int k = 0; k < N_ENT; k++) begin
      if (vec_i[k]) begin
        hit_o = 1'b1;
        pos_o = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/ldst_hazard_gate.sv
module ldst_hazard_gate
  import ldst_hz_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic                         ld_valid_i,
  input  logic [ADDR_W-1:0]            ld_addr_i,
  input  logic [IDX_W-1:0]             ld_idx_i,
  input  logic [IDX_W-1:0]             head_idx_i,
  input  logic [N_ENT-1:0]             ent_busy_i,
  input  logic [N_ENT-1:0]             ent_is_st_i,
  input  logic [N_ENT-1:0]             ent_addr_ok_i,
  input  logic [N_ENT-1:0][ADDR_W-1:0] ent_addr_i,
  output logic                         ld_go_o,
  output logic                         ld_stall_o,
  output logic [IDX_W-1:0]             blk_idx_o
);
  logic [N_ENT-1:0] cand;
  logic [N_ENT-1:0] ord;
  logic             hit;
  logic [IDX_W-1:0] hit_age;
  logic [IDX_W-1:0] hit_idx;

  hz_ent_cmp #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_cmp (
    .ld_addr_i    (ld_addr_i),
    .ent_busy_i   (ent_busy_i),
    .ent_is_st_i  (ent_is_st_i),
    .ent_addr_ok_i(ent_addr_ok_i),
    .ent_addr_i   (ent_addr_i),
    .cand_o       (cand)
  );

  hz_age_rot #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_rot (
    .head_i  (head_idx_i),
    .ld_idx_i(ld_idx_i),
    .cand_i  (cand),
    .ord_o   (ord)
  );

  hz_pick_hi #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
    .vec_i(ord),
    .hit_o(hit),
    .pos_o(hit_age)
  );

  // age back to buffer index
  assign hit_idx    = IDX_W'(ring_add(int'(head_idx_i), int'(hit_age), N_ENT));

  assign ld_go_o    = ld_valid_i & ~hit;
  assign ld_stall_o = ld_valid_i & hit;
  assign blk_idx_o  = ld_stall_o ? hit_idx : '0;
endmodule

// File: rtl/ldst_hazard_gate_chk.sv
module ldst_hazard_gate_chk
  import ldst_hz_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input logic                         ld_valid_i,
  input logic [ADDR_W-1:0]            ld_addr_i,
  input logic [IDX_W-1:0]             ld_idx_i,
  input logic [IDX_W-1:0]             head_idx_i,
  input logic [N_ENT-1:0]             ent_busy_i,
  input logic [N_ENT-1:0]             ent_is_st_i,
  input logic [N_ENT-1:0]             ent_addr_ok_i,
  input logic [N_ENT-1:0][ADDR_W-1:0] ent_addr_i,
  input logic                         ld_go_o,
  input logic                         ld_stall_o,
  input logic [IDX_W-1:0]             blk_idx_o
);
  int unsigned ld_age;
  int unsigned blk_age;

  assign ld_age  = ring_dist(int'(ld_idx_i), int'(head_idx_i), N_ENT);
  assign blk_age = ring_dist(int'(blk_idx_o), int'(head_idx_i), N_ENT);

  always_comb begin
    p_idle_quiet_r1: assert (ld_valid_i || (!ld_go_o && !ld_stall_o && blk_idx_o == '0))
      else $error("idle load produced output");
    p_excl_r10: assert (!(ld_go_o && ld_stall_o))
      else $error("grant and stall together");
    p_cover_r10: assert ((ld_go_o || ld_stall_o) == ld_valid_i)
      else $error("valid load neither granted nor stalled");
    p_head_go_r11: assert (!(ld_valid_i && ld_idx_i == head_idx_i) || ld_go_o)
      else $error("load at head not granted");
    if (ld_stall_o && int'(blk_idx_o) < N_ENT) begin
      p_blk_store_r6: assert (ent_busy_i[blk_idx_o] && ent_is_st_i[blk_idx_o])
        else $error("blocker is not an active store");
      p_blk_older_r7: assert (blk_age < ld_age)
        else $error("blocker not older than load");
      p_blk_addr_r3: assert (!ent_addr_ok_i[blk_idx_o] || ent_addr_i[blk_idx_o] == ld_addr_i)
        else $error("blocker address neither unresolved nor matching");
    end
  end
endmodule

bind ldst_hazard_gate ldst_hazard_gate_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_chk (
  .ld_valid_i   (ld_valid_i),
  .ld_addr_i    (ld_addr_i),
  .ld_idx_i     (ld_idx_i),
  .head_idx_i   (head_idx_i),
  .ent_busy_i   (ent_busy_i),
  .ent_is_st_i  (ent_is_st_i),
  .ent_addr_ok_i(ent_addr_ok_i),
  .ent_addr_i   (ent_addr_i),
  .ld_go_o      (ld_go_o),
  .ld_stall_o   (ld_stall_o),
  .blk_idx_o    (blk_idx_o)
);

// File: tb/ldst_hazard_gate_tb.sv
`timescale 1ns/1ps
module ldst_hazard_gate_tb;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 ld_valid;
  logic [AW-1:0]        ld_addr;
  logic [IW-1:0]        ld_idx;
  logic [IW-1:0]        head;
  logic [N-1:0]         busy, is_st, addr_ok;
  logic [N-1:0][AW-1:0] addr;
  logic                 go, stall;
  logic [IW-1:0]        blk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ldst_hazard_gate #(.N_ENT(N), .ADDR_W(AW)) u_dut (
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_idx_i(ld_idx), .head_idx_i(head),
    .ent_busy_i(busy), .ent_is_st_i(is_st), .ent_addr_ok_i(addr_ok), .ent_addr_i(addr),
    .ld_go_o(go), .ld_stall_o(stall), .blk_idx_o(blk)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // class: 0 idle entry, 1 non-store, 2 unresolved store, 3 matching store, 4 mismatching store
  task automatic set_ent(int e, int cls);
    busy[e]    = (cls != 0);
    is_st[e]   = (cls != 1);
    addr_ok[e] = (cls != 2);
    addr[e]    = (cls == 2) ? ld_addr ^ 8'h5A : (cls == 4) ? ld_addr ^ 8'h80 : ld_addr;
  endtask

  task automatic clear_all();
    for (int e = 0; e < N; e++) set_ent(e, 0);
  endtask

  // reference: youngest older store with resolved-equal or unresolved address
  task automatic expect_out(output bit e_stall, output int e_idx, output bit e_unres,
                            output bit e_young);
    int la, ea;
    la = (int'(ld_idx) - int'(head) + N) % N;
    e_stall = 0; e_idx = 0; e_unres = 0; e_young = 0;
    for (int a = 0; a < N; a++) begin
      int e;
      bit c;
      e  = (int'(head) + a) % N;
      ea = a;
      c  = busy[e] && is_st[e] && (!addr_ok[e] || addr[e] == ld_addr);
      if (c && ea < la) begin
        e_stall = 1; e_idx = e; e_unres = !addr_ok[e];
      end else if (c) e_young = 1;
    end
    if (!ld_valid) begin e_stall = 0; e_idx = 0; end
  endtask

  task automatic eval(string tag);
    bit es, eu, ey;
    int ei;
    #1;
    expect_out(es, ei, eu, ey);
    chk(stall == es, tag, int'(stall), int'(es));
    chk(go == (ld_valid && !es), tag, int'(go), int'(ld_valid && !es));
    chk(int'(blk) == ei, tag, int'(blk), ei);
    @(negedge clk);
  endtask

  initial begin
    ld_valid = 0; ld_addr = 8'h3C; ld_idx = 0; head = 0;
    clear_all();
    @(negedge clk);

    // R1: idle load with an older matching store present
    head = 0; ld_idx = 3; set_ent(0, 3);
    eval("R1");
    ld_valid = 1;

    // R3 and R2
    eval("R3");
    clear_all(); eval("R2");

    // R4: unresolved older store, address field differs
    set_ent(1, 2); eval("R4");

    // R5: inactive matching entry
    clear_all(); set_ent(1, 0); busy[1] = 0; is_st[1] = 1; addr_ok[1] = 1; eval("R5");

    // R6: non-store with matching address
    clear_all(); set_ent(2, 1); eval("R6");

    // R7: younger matching store, head=2, load idx 3 (age 1), store at idx 0 (age 2)
    clear_all(); head = 2; ld_idx = 3; set_ent(0, 3); eval("R7");
    // same store older after wrap: load idx 1 (age 3)
    ld_idx = 1; eval("R7");

    // R8: single-bit address differences on an older resolved store
    for (int b = 0; b < AW; b++) begin
      clear_all(); head = 0; ld_idx = 3; set_ent(1, 3);
      addr[1] = ld_addr ^ AW'(1 << b);
      eval("R8");
    end

    // R9: two matches at ages 0 and 2, youngest older is age 2
    clear_all(); head = 1; ld_idx = 0; set_ent(1, 3); set_ent(3, 3); eval("R9");
    // unresolved at age 1 beats match at age 0
    clear_all(); head = 1; ld_idx = 0; set_ent(1, 3); set_ent(2, 2); eval("R9");

    // R11: load at head with every other entry a matching store
    for (int h = 0; h < N; h++) begin
      head = IW'(h); ld_idx = IW'(h);
      for (int e = 0; e < N; e++) set_ent(e, 3);
      eval("R11");
    end

    // sweep: every head, load index and entry-class mix; R10 checked per pattern
    for (int h = 0; h < N; h++) begin
      for (int li = 0; li < N; li++) begin
        for (int code = 0; code < 625; code++) begin
          bit es, eu, ey;
          int ei, c;
          string tag;
          head = IW'(h); ld_idx = IW'(li);
          ld_addr = AW'(code * 37 + h);
          c = code;
          for (int e = 0; e < N; e++) begin set_ent(e, c % 5); c = c / 5; end
          #1;
          expect_out(es, ei, eu, ey);
          tag = es ? (eu ? "R4" : "R3") : (ey ? "R7" : "R2");
          chk(stall == es, tag, int'(stall), int'(es));
          chk(int'(blk) == ei, "R9", int'(blk), ei);
          chk((go ^ stall) == 1'b1, "R10", int'(go ^ stall), 1);
          @(negedge clk);
        end
      end
    end

    // R1 again over idle sweep of heads
    ld_valid = 0;
    for (int h = 0; h < N; h++) begin
      head = IW'(h); ld_idx = IW'((h + 3) % N);
      for (int e = 0; e < N; e++) set_ent(e, 2);
      eval("R1");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule